// File: doc/BRIEF.md
# Multi-Line Transmit DMA Scheduler

This block moves outgoing bytes from memory to up to sixteen serial transmitters. Every line has a private 18-bit current-address register and a private 16-bit byte counter. Both sit behind one shared register window. Software picks the line to access through the low bits of the control word. It loads that line's address and a negative byte count, then sets the line's bit in the active mask. From then on the block works on its own. It issues one-byte read requests to memory, hands each returned byte to the owning line's transmitter, and moves the address and count forward.

When a line's count reaches zero, hardware clears that line's active bit and raises the transmit-done flag. If software has enabled it, this also raises an interrupt. Software can cut a running line short by writing a count of all ones. The address register then shows the first byte that was not sent. A read that memory never answers is abandoned after a fixed number of cycles, and the abandonment is recorded in a sticky flag. A master-clear bit stops all lines at once.

Top module: `txdma_sched`

## Requirements
- R1: `reg_addr` selects one of four registers: 0 is the control word, 1 is the address, 2 is the count and 3 is the active mask. Control bits [3:0] choose the line whose address and count are read and written through offsets 1 and 2. No other line changes on such an access.
- R2: A write to offset 1 stores `reg_wdata` as address bits [15:0]. It takes control bits [5:4] as address bits [17:16]. Reads of offset 1 return bits [15:0]. Each byte fetch uses the full 18-bit address, and the address then advances by one, carrying into bit 16.
- R3: Offset 2 holds the two's-complement negative of the bytes still to send. It rises by one per byte, and a line sends exactly that many bytes. A line started with a count of zero is retired without any fetch.
- R4: A write to offset 3 sets each active bit whose data bit is one. Zero data bits leave the mask unchanged. Hardware clears a line's bit when the line finishes.
- R5: Any line finishing sets control bit 15. `irq` is high while bits 15 and 13 are both one. A control write with bit 15 zero clears the flag, and a write with bit 15 one does not set it.
- R6: Writing 0xFFFF to the count of an active line ends that line after one further byte. The address register is then left pointing at the next unsent byte, and the count reads zero.
- R7: A fetch that receives no `mem_ack` within NXM_TIMEOUT cycles sets control bit 10, retires the line without sending, and sets bit 15. A control write with bit 8 set clears bit 10.
- R8: Active lines are served one byte at a time, in rising index order starting after the line served last, wrapping around. No request is made while the mask is empty.
- R9: A control write with bit 11 set clears every active bit, every count, and bits 15 and 10. It also drops any outstanding fetch.
- R10: `mem_req` stays high with a stable `mem_addr` until `mem_ack`. Each acknowledged byte appears on `tx_data` with `tx_valid` high one cycle later, and `tx_line` names its line.
- R11: After reset all registers, the mask and the flags read zero, and `mem_req`, `tx_valid` and `irq` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register offset |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational) |
| irq | output | 1 | Transmit-done interrupt request |
| mem_req | output | 1 | Byte read request |
| mem_addr | output | 18 | Byte read address |
| mem_ack | input | 1 | Read answered, data valid |
| mem_data | input | 8 | Read data |
| tx_valid | output | 1 | Byte delivered to a transmitter |
| tx_line | output | 4 | Line owning the delivered byte |
| tx_data | output | 8 | Delivered byte |

## Verification
The bench builds the block with NUM_LINES at 16 and NXM_TIMEOUT at 16. With sixteen lines, the full four-bit select field and the highest line index are both exercised, and the round-robin pointer wraps from line 15 back to 0. The short timeout lets an unanswered fetch to the top address quarter expire within a few dozen cycles. A memory model with an adjustable latency keeps requests pending long enough for stop requests, master clear and mask writes to land in the middle of a transfer.

// File: rtl/txdma_pkg.sv
package txdma_pkg;

    localparam int REG_W  = 16;
    localparam int ADDR_W = 18;
    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        RG_CTRL   = 2'd0,
        RG_ADDR   = 2'd1,
        RG_COUNT  = 2'd2,
        RG_ACTIVE = 2'd3
    } reg_sel_e;

    localparam int CB_NXM_CLR = 8;
    localparam int CB_NXM     = 10;
    localparam int CB_MCLR    = 11;
    localparam int CB_TIE     = 13;
    localparam int CB_TI      = 15;

    typedef enum logic {
        FS_IDLE = 1'b0,
        FS_WAIT = 1'b1
    } fetch_state_e;

    typedef struct packed {
        logic       valid;
        logic [3:0] line;
    } step_evt_t;

    typedef struct packed {
        logic       valid;
        logic [3:0] line;
        logic       nxm;
    } retire_evt_t;

    function automatic logic [ADDR_W-1:0] join_addr(input logic [1:0] hi,
                                                    input logic [REG_W-1:0] lo);
        return {hi, lo};
    endfunction

endpackage

// File: rtl/txdma_rr_arb.sv
module txdma_rr_arb
    import txdma_pkg::*;
#(
    parameter int N  = 16,
    parameter int LW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [N-1:0]  req,
    input  logic          take,
    output logic          found,
    output logic [LW-1:0] pick
);

    logic [LW-1:0] last_q;

    always_comb begin
        found = 1'b0;
        pick  = '0;
        for (int k = 1; k <= N; k++) begin
            if (!found && req[(int'(last_q) + k) % N]) begin
                found = 1'b1;
                pick  = LW'((int'(last_q) + k) % N);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)       last_q <= LW'(N - 1);
        else if (take) last_q <= pick;
    end

endmodule

// File: rtl/txdma_lines.sv
module txdma_lines
    import txdma_pkg::*;
#(
    parameter int N  = 16,
    parameter int LW = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  reg_sel_e          reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  step_evt_t         step,
    input  retire_evt_t       retire,
    input  logic [LW-1:0]     pick,
    output logic [ADDR_W-1:0] pick_addr,
    output logic              pick_zero,
    output logic [N-1:0]      act_mask,
    output logic              mclr,
    output logic              irq
);

    logic ctrl_wr, addr_wr, cnt_wr, act_wr;
    logic [3:0] sel_q;
    logic [1:0] hi_q;
    logic tie_q, ti_q, nxm_q;
    logic [N-1:0] clr_mask, act_q;
    logic [ADDR_W-1:0] car_w [N];
    logic [REG_W-1:0]  cnt_w [N];

    assign ctrl_wr = reg_we && (reg_addr == RG_CTRL);
    assign addr_wr = reg_we && (reg_addr == RG_ADDR);
    assign cnt_wr  = reg_we && (reg_addr == RG_COUNT);
    assign act_wr  = reg_we && (reg_addr == RG_ACTIVE);
    assign mclr    = ctrl_wr && reg_wdata[CB_MCLR];

    for (genvar g = 0; g < N; g++) begin : g_line
        logic [ADDR_W-1:0] car_q;
        logic [REG_W-1:0]  cnt_q;
        logic hit_step, hit_sel;

        assign hit_step = step.valid && (step.line == 4'(g));
        assign hit_sel  = (sel_q[LW-1:0] == LW'(g));
        assign clr_mask[g] = (hit_step && (cnt_q == '1)) ||
                             (retire.valid && (retire.line == 4'(g)));
        assign car_w[g] = car_q;
        assign cnt_w[g] = cnt_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                car_q <= '0;
                cnt_q <= '0;
            end else begin
                if (hit_step) begin
                    car_q <= car_q + 1'b1;
                    cnt_q <= cnt_q + 1'b1;
                end
                if (mclr)               cnt_q <= '0;
                if (addr_wr && hit_sel) car_q <= join_addr(hi_q, reg_wdata);
                if (cnt_wr && hit_sel)  cnt_q <= reg_wdata;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q <= '0;
            sel_q <= '0;
            hi_q  <= '0;
            tie_q <= 1'b0;
            ti_q  <= 1'b0;
            nxm_q <= 1'b0;
        end else begin
            act_q <= (act_q & ~clr_mask) | (act_wr ? reg_wdata[N-1:0] : '0);
            if (ctrl_wr) begin
                sel_q <= reg_wdata[3:0];
                hi_q  <= reg_wdata[5:4];
                tie_q <= reg_wdata[CB_TIE];
            end
            if (|clr_mask)                          ti_q <= 1'b1;
            else if (ctrl_wr && !reg_wdata[CB_TI])  ti_q <= 1'b0;
            if (retire.valid && retire.nxm)             nxm_q <= 1'b1;
            else if (ctrl_wr && reg_wdata[CB_NXM_CLR])  nxm_q <= 1'b0;
            if (mclr) begin
                act_q <= '0;
                ti_q  <= 1'b0;
                nxm_q <= 1'b0;
            end
        end
    end

    always_comb begin
        unique case (reg_addr)
            RG_CTRL:   reg_rdata = {ti_q, 1'b0, tie_q, 2'b00, nxm_q, 4'b0000, hi_q, sel_q};
            RG_ADDR:   reg_rdata = car_w[sel_q[LW-1:0]][REG_W-1:0];
            RG_COUNT:  reg_rdata = cnt_w[sel_q[LW-1:0]];
            default:   reg_rdata = REG_W'(act_q);
        endcase
    end

    assign pick_addr = car_w[pick];
    assign pick_zero = (cnt_w[pick] == '0);
    assign act_mask  = act_q;
    assign irq       = ti_q && tie_q;

endmodule

// File: rtl/txdma_fetch.sv
module txdma_fetch
    import txdma_pkg::*;
#(
    parameter int LW  = 4,
    parameter int TMO = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              abort,
    input  logic              found,
    input  logic [LW-1:0]     pick,
    input  logic [ADDR_W-1:0] pick_addr,
    input  logic              pick_zero,
    output logic              take,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_ack,
    input  logic [BYTE_W-1:0] mem_data,
    output step_evt_t         step,
    output retire_evt_t       retire,
    output logic              tx_valid,
    output logic [LW-1:0]     tx_line,
    output logic [BYTE_W-1:0] tx_data
);

    localparam int TW = (TMO > 1) ? $clog2(TMO) : 1;

    fetch_state_e      state_q;
    logic [LW-1:0]     cur_line_q;
    logic [ADDR_W-1:0] cur_addr_q;
    logic [TW-1:0]     timer_q;
    logic got, expire;

    assign take     = (state_q == FS_IDLE) && found && !abort;
    assign mem_req  = (state_q == FS_WAIT);
    assign mem_addr = cur_addr_q;
    assign got      = mem_req && mem_ack && !abort;
    assign expire   = mem_req && !mem_ack && !abort && (timer_q == TW'(TMO - 1));

    always_comb begin
        step.valid   = got;
        step.line    = 4'(cur_line_q);
        retire.valid = (take && pick_zero) || expire;
        retire.line  = expire ? 4'(cur_line_q) : 4'(pick);
        retire.nxm   = expire;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= FS_IDLE;
            cur_line_q <= '0;
            cur_addr_q <= '0;
            timer_q    <= '0;
            tx_valid   <= 1'b0;
            tx_line    <= '0;
            tx_data    <= '0;
        end else begin
            tx_valid <= got;
            if (got) begin
                tx_line <= cur_line_q;
                tx_data <= mem_data;
            end
            case (state_q)
                FS_IDLE: begin
                    if (take && !pick_zero) begin
                        state_q    <= FS_WAIT;
                        cur_line_q <= pick;
                        cur_addr_q <= pick_addr;
                        timer_q    <= '0;
                    end
                end
                default: begin
                    if (abort || got || expire) state_q <= FS_IDLE;
                    else                        timer_q <= timer_q + 1'b1;
                end
            endcase
        end
    end

endmodule

// File: rtl/txdma_sched.sv
module txdma_sched
    import txdma_pkg::*;
#(
    parameter int NUM_LINES   = 16,
    parameter int NXM_TIMEOUT = 64
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_we,
    input  logic [1:0]  reg_addr,
    input  logic [15:0] reg_wdata,
    output logic [15:0] reg_rdata,
    output logic        irq,
    output logic        mem_req,
    output logic [17:0] mem_addr,
    input  logic        mem_ack,
    input  logic [7:0]  mem_data,
    output logic        tx_valid,
    output logic [3:0]  tx_line,
    output logic [7:0]  tx_data
);

    localparam int LW = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1;

    logic [NUM_LINES-1:0] act_mask;
    logic                 mclr, found, take, pick_zero;
    logic [LW-1:0]        pick, tx_line_w;
    logic [ADDR_W-1:0]    pick_addr;
    step_evt_t            step;
    retire_evt_t          retire;

    txdma_lines #(.N(NUM_LINES), .LW(LW)) u_lines (
        .clk(clk), .rst(rst),
        .reg_we(reg_we), .reg_addr(reg_sel_e'(reg_addr)),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .step(step), .retire(retire),
        .pick(pick), .pick_addr(pick_addr), .pick_zero(pick_zero),
        .act_mask(act_mask), .mclr(mclr), .irq(irq)
    );

    txdma_rr_arb #(.N(NUM_LINES), .LW(LW)) u_arb (
        .clk(clk), .rst(rst),
        .req(act_mask), .take(take),
        .found(found), .pick(pick)
    );

    txdma_fetch #(.LW(LW), .TMO(NXM_TIMEOUT)) u_fetch (
        .clk(clk), .rst(rst), .abort(mclr),
        .found(found), .pick(pick), .pick_addr(pick_addr), .pick_zero(pick_zero),
        .take(take),
        .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_ack(mem_ack), .mem_data(mem_data),
        .step(step), .retire(retire),
        .tx_valid(tx_valid), .tx_line(tx_line_w), .tx_data(tx_data)
    );

    assign tx_line = 4'(tx_line_w);

endmodule

// File: rtl/txdma_sched_chk.sv
module txdma_sched_chk #(
    parameter int N = 16
) (
    input logic         clk,
    input logic         rst,
    input logic         mclr,
    input logic         mem_req,
    input logic         mem_ack,
    input logic [17:0]  mem_addr,
    input logic         tx_valid,
    input logic         irq,
    input logic [N-1:0] act_mask
);

    assert_req_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (!mem_req || $stable(mem_addr)));

    assert_tx_follows_ack_R10: assert property (@(posedge clk) disable iff (rst)
        tx_valid |-> $past(mem_req && mem_ack));

    assert_master_clear_R9: assert property (@(posedge clk) disable iff (rst)
        mclr |=> (act_mask == '0 && !irq && !mem_req));

    assert_req_needs_active_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_req) |-> ($past(act_mask) != '0));

    assert_quiet_after_reset_R11: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!irq && !mem_req && !tx_valid && act_mask == '0));

endmodule

bind txdma_sched txdma_sched_chk #(.N(NUM_LINES)) u_chk (
    .clk(clk), .rst(rst), .mclr(mclr),
    .mem_req(mem_req), .mem_ack(mem_ack), .mem_addr(mem_addr),
    .tx_valid(tx_valid), .irq(irq), .act_mask(act_mask)
);

// File: tb/txdma_sched_test.sv
module txdma_sched_test;

    localparam int CLK_PERIOD = 10;
    localparam int N   = 16;
    localparam int TMO = 16;
    localparam logic [1:0] A_CTRL = 2'd0, A_ADDR = 2'd1, A_CNT = 2'd2, A_ACT = 2'd3;

    // line[37:34] hi[33:32] lo[31:16] nbytes[15:8] latency[7:0]
    localparam logic [37:0] VECS [5] = '{
        {4'd0,  2'd0, 16'h0010, 8'd3, 8'd0},
        {4'd15, 2'd1, 16'hFFFE, 8'd4, 8'd2},
        {4'd7,  2'd2, 16'h1234, 8'd1, 8'd1},
        {4'd3,  2'd0, 16'h8000, 8'd8, 8'd3},
        {4'd9,  2'd1, 16'h00FF, 8'd2, 8'd0}
    };

    logic        clk = 1'b0, rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [15:0] reg_wdata = 16'd0;
    logic [15:0] reg_rdata;
    logic        irq, mem_req, tx_valid;
    logic [17:0] mem_addr;
    logic        mem_ack = 1'b0;
    logic [7:0]  mem_data = 8'd0;
    logic [3:0]  tx_line;
    logic [7:0]  tx_data;

    int n_vec = 0, n_bad = 0;
    int mem_lat = 0, wait_c = 0;
    int lg_n = 0;
    logic [3:0] lg_line [512];
    logic [7:0] lg_data [512];
    bit finished = 0;

    txdma_sched #(.NUM_LINES(N), .NXM_TIMEOUT(TMO)) uut (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack),
        .mem_data(mem_data), .tx_valid(tx_valid), .tx_line(tx_line),
        .tx_data(tx_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [7:0] mem_byte(input logic [17:0] a);
        return a[7:0] ^ {a[17:16], a[13:8]};
    endfunction

    // memory model: top address quarter never answers
    always @(negedge clk) begin
        if (mem_req && !mem_ack && mem_addr[17:16] != 2'b11) begin
            if (wait_c >= mem_lat) begin
                mem_ack  <= 1'b1;
                mem_data <= mem_byte(mem_addr);
                wait_c   <= 0;
            end else begin
                wait_c <= wait_c + 1;
            end
        end else begin
            mem_ack <= 1'b0;
            if (!mem_req) wait_c <= 0;
        end
    end

    always @(negedge clk) begin
        if (tx_valid) begin
            lg_line[lg_n % 512] = tx_line;
            lg_data[lg_n % 512] = tx_data;
            lg_n = lg_n + 1;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic wait_idle(input string tag);
        logic [15:0] d;
        int k;
        k = 0;
        do begin
            rd(A_ACT, d);
            k++;
        end while (d != 16'd0 && k < 3000);
        chk(tag, d, 16'd0);
    endtask

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: actual running expected done");
            summary();
            $finish;
        end
    end

    logic [37:0] e;
    logic [3:0]  v_line;
    logic [1:0]  v_hi;
    logic [15:0] v_lo, d;
    logic [17:0] full;
    int v_n, base, errs, k, k1, i2, i5;

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R11 reset state
        rd(A_CTRL, d); chk("R11 ctrl", d, 16'h0000);
        rd(A_ACT, d);  chk("R11 active", d, 16'h0000);
        rd(A_CNT, d);  chk("R11 count", d, 16'h0000);
        chk("R11 irq/req/txv", {irq, mem_req, tx_valid}, 3'b000);

        // R1 line selection through control bits [3:0]
        wr(A_CTRL, 16'h0004); wr(A_ADDR, 16'hAAAA); wr(A_CNT, 16'h1111);
        wr(A_CTRL, 16'h0005); wr(A_ADDR, 16'h5555); wr(A_CNT, 16'h2222);
        wr(A_CTRL, 16'h0004);
        rd(A_ADDR, d); chk("R1 addr line4", d, 16'hAAAA);
        rd(A_CNT, d);  chk("R1 count line4", d, 16'h1111);
        wr(A_CTRL, 16'h0005);
        rd(A_ADDR, d); chk("R1 addr line5", d, 16'h5555);

        // vector table: one line per vector
        for (int v = 0; v < 5; v++) begin
            e = VECS[v];
            v_line = e[37:34]; v_hi = e[33:32]; v_lo = e[31:16];
            v_n = int'(e[15:8]); mem_lat = int'(e[7:0]);
            wr(A_CTRL, 16'h2000 | {10'd0, v_hi, v_line});
            wr(A_ADDR, v_lo);
            wr(A_CNT, 16'(-v_n));
            base = lg_n;
            wr(A_ACT, 16'(1 << v_line));
            wait_idle("R4 vector active cleared");
            chk("R3 byte total", lg_n - base, v_n);
            errs = 0;
            for (int i = 0; i < v_n; i++) begin
                full = {v_hi, v_lo} + 18'(i);
                if (lg_line[(base + i) % 512] !== v_line ||
                    lg_data[(base + i) % 512] !== mem_byte(full)) errs++;
            end
            chk("R10 R2 byte stream", errs, 0);
            rd(A_ADDR, d); chk("R2 final address", d, 16'(v_lo + 16'(v_n)));
            rd(A_CNT, d);  chk("R3 final count", d, 16'h0000);
            rd(A_CTRL, d); chk("R5 done flag", d[15], 1'b1);
            chk("R5 irq", irq, 1'b1);
        end

        // R5 flag write semantics
        wr(A_CTRL, 16'h8000);
        rd(A_CTRL, d); chk("R5 write one keeps flag", d[15], 1'b1);
        chk("R5 irq masked", irq, 1'b0);
        wr(A_CTRL, 16'h2000);
        rd(A_CTRL, d); chk("R5 write zero clears", d[15], 1'b0);
        chk("R5 irq low", irq, 1'b0);

        // R8 round robin between two lines
        mem_lat = 0;
        wr(A_CTRL, 16'h2002); wr(A_ADDR, 16'h0100); wr(A_CNT, 16'hFFFD);
        wr(A_CTRL, 16'h2005); wr(A_ADDR, 16'h0200); wr(A_CNT, 16'hFFFD);
        base = lg_n;
        wr(A_ACT, 16'h0024);
        wait_idle("R8 both lines done");
        chk("R8 byte total", lg_n - base, 6);
        errs = 0; i2 = 0; i5 = 0;
        for (int i = 0; i < 6; i++) begin
            if (i > 0 && lg_line[(base + i) % 512] == lg_line[(base + i - 1) % 512]) errs++;
            if (lg_line[(base + i) % 512] == 4'd2) begin
                if (lg_data[(base + i) % 512] !== mem_byte(18'h00100 + 18'(i2))) errs++;
                i2++;
            end else begin
                if (lg_data[(base + i) % 512] !== mem_byte(18'h00200 + 18'(i5))) errs++;
                i5++;
            end
        end
        chk("R8 alternation and order", errs, 0);

        // R4 writing zeros to the mask does not stop a line
        mem_lat = 6;
        wr(A_CTRL, 16'h2001); wr(A_ADDR, 16'h0600); wr(A_CNT, 16'hFFFC);
        base = lg_n;
        wr(A_ACT, 16'h0002);
        wr(A_ACT, 16'h0000);
        rd(A_ACT, d); chk("R4 zero write ignored", d, 16'h0002);
        wait_idle("R4 line finished");
        chk("R4 all bytes sent", lg_n - base, 4);

        // R6 stop request
        mem_lat = 5;
        wr(A_CTRL, 16'h2006); wr(A_ADDR, 16'h0300); wr(A_CNT, 16'hFFD8);
        base = lg_n;
        wr(A_ACT, 16'h0040);
        repeat (30) @(negedge clk);
        wr(A_CTRL, 16'h2006);
        wr(A_CNT, 16'hFFFF);
        wait_idle("R6 line stopped");
        k = lg_n - base;
        chk("R6 ended early", (k >= 1 && k < 40), 1'b1);
        rd(A_ADDR, d); chk("R6 address shows progress", d, 16'(16'h0300 + 16'(k)));
        rd(A_CNT, d);  chk("R6 count zero", d, 16'h0000);

        // R3 zero count retires without fetch
        wr(A_CTRL, 16'h2008); wr(A_CNT, 16'h0000);
        base = lg_n;
        wr(A_ACT, 16'h0100);
        repeat (5) @(negedge clk);
        rd(A_ACT, d);  chk("R3 zero count retired", d, 16'h0000);
        chk("R3 zero count no bytes", lg_n - base, 0);
        rd(A_CTRL, d); chk("R3 zero count flag", d[15], 1'b1);

        // R7 unanswered fetch
        wr(A_CTRL, 16'h203A); wr(A_ADDR, 16'h0000); wr(A_CNT, 16'hFFFE);
        base = lg_n;
        wr(A_ACT, 16'h0400);
        wait_idle("R7 line retired");
        rd(A_CTRL, d);
        chk("R7 nxm flag", d[10], 1'b1);
        chk("R7 done flag", d[15], 1'b1);
        chk("R7 no bytes", lg_n - base, 0);
        wr(A_CTRL, 16'h213A);
        rd(A_CTRL, d); chk("R7 nxm cleared", d[10], 1'b0);

        // R9 master clear mid transfer
        mem_lat = 5;
        wr(A_CTRL, 16'h200B); wr(A_ADDR, 16'h0500); wr(A_CNT, 16'hFFCE);
        wr(A_ACT, 16'h0800);
        repeat (20) @(negedge clk);
        wr(A_CTRL, 16'h280B);
        rd(A_ACT, d);  chk("R9 mask cleared", d, 16'h0000);
        rd(A_CNT, d);  chk("R9 count cleared", d, 16'h0000);
        rd(A_CTRL, d); chk("R9 flags cleared", {d[15], d[10]}, 2'b00);
        chk("R9 irq low", irq, 1'b0);
        k1 = lg_n;
        repeat (20) @(negedge clk);
        chk("R9 no more bytes", lg_n, k1);
        chk("R9 request dropped", mem_req, 1'b0);

        finished = 1;
        summary();
        $finish;
    end

endmodule